// File: doc/BRIEF.md
# Interleaved Bank Request Scheduler

This block sits between a single processing unit and a set of independent memory banks that together form one word-addressed space. Each incoming request is routed to a bank chosen from the least significant bits of its word address. The rest of the address selects a row inside that bank. Once a bank accepts an access it cannot take another for a fixed number of cycles. Requests that target an occupied bank wait in an eight-entry holding queue and are issued as soon as their bank becomes free.

Reads are preferred over queued writes, so writes mostly drain in cycles that no read could use. A read never overtakes an older write to the same word. Every read carries a tag. The banks return read data a fixed number of cycles after accepting the read. The scheduler picks that data off the bus of the bank that served the read and hands it back with the read's tag.

When addresses are sequential and the bank count exceeds the busy time, the block sustains one access per cycle.

Top module: `interleave_sched`

## Requirements
- R1: While reset is held, `req_ready` is 1, `bank_en` is all zero and `rsp_valid` is 0.
- R2: The bank index is the low log2(NB) bits of the word address and is driven one-hot on `bank_en`. The remaining upper bits appear on `bank_row`.
- R3: A bank enabled in cycle c is not enabled again before cycle c+BUSY. Accesses queued behind one another on the same bank are issued exactly BUSY cycles apart.
- R4: At most one bit of `bank_en` is set in any cycle. A run of back-to-back sequential accesses issues one access per cycle when NB > BUSY.
- R5: Among the requests whose bank is free, the oldest read is issued first. A write is issued only in a cycle in which no queued read can issue.
- R6: A read does not issue while an older write to the same word address is still queued.
- R7: At most DEPTH requests are held at once. `req_ready` is 0 exactly when DEPTH requests are held. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, and it can issue from the following cycle.
- R8: A read issued to bank b in cycle c produces `rsp_valid` in cycle c+LAT. In that cycle `rsp_tag` equals the read's `req_tag` and `rsp_data` is taken from slice b of `bank_rdata` (bits b*DW upward).
- R9: Every read returns the value of the most recent older write to its address, in request order. Every accepted read produces exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has a free entry |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_tag | input | TW | Read tag echoed on the response |
| bank_en | output | NB | One-hot bank access strobe |
| bank_we | output | 1 | Access is a write |
| bank_row | output | AW-log2(NB) | Row within the bank |
| bank_wdata | output | DW | Data for a write access |
| bank_rdata | input | NB*DW | Read data bus of every bank, bank b in slice b |
| rsp_valid | output | 1 | Read response present |
| rsp_tag | output | TW | Tag of the returned read |
| rsp_data | output | DW | Returned read data |

## Verification
The bench builds the block with eight banks, a busy time of four, a return latency of three, an eight-entry queue and a 64-word space. That space is small enough to write every word and read every word back in sequential streams. The configuration also makes queue saturation on a single bank, bypass of blocked writes and same-address hazards easy to stage with only a handful of requests. A long pseudo-random mix then covers every bank and row against an arithmetic reference memory. A bank model in the bench enforces the busy window and the return latency on every access.

// File: rtl/interleave_pkg.sv
`timescale 1ns/1ps
package interleave_pkg;

  // Bank selected by a word address: low-order bits.
  function automatic int unsigned bank_index(int unsigned addr, int unsigned bw);
    return addr & ((32'd1 << bw) - 32'd1);
  endfunction

  // Row inside the bank: the address bits above the bank field.
  function automatic int unsigned row_index(int unsigned addr, int unsigned bw);
    return addr >> bw;
  endfunction

  // Counter load after an access so that the bank is held for busy cycles in total.
  function automatic int unsigned busy_reload(int unsigned busy);
    return (busy == 0) ? 0 : busy - 1;
  endfunction

endpackage

// File: rtl/iq_queue.sv
`timescale 1ns/1ps
module iq_queue
  import interleave_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int TW    = 5,
  parameter int NB    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_we,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic [TW-1:0] push_tag,
  input  logic [NB-1:0] bank_busy,
  output logic          full,
  output logic          iss_valid,
  output logic          iss_we,
  output logic [AW-1:0] iss_addr,
  output logic [DW-1:0] iss_data,
  output logic [TW-1:0] iss_tag
);
  localparam int BW = $clog2(NB);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  // Entry 0 is always the oldest; entries compact downward on removal.
  logic [DEPTH-1:0] v_q, we_q, v_n, we_n;
  logic [AW-1:0]    a_q [DEPTH];
  logic [AW-1:0]    a_n [DEPTH];
  logic [DW-1:0]    d_q [DEPTH];
  logic [DW-1:0]    d_n [DEPTH];
  logic [TW-1:0]    t_q [DEPTH];
  logic [TW-1:0]    t_n [DEPTH];
  logic [CW-1:0]    cnt_q;

  logic [DEPTH-1:0] rd_ok, wr_ok, haz;
  logic             rd_any, wr_any;
  logic [IW-1:0]    rd_idx, wr_idx, sel;

  always_comb begin : readiness
    for (int i = 0; i < DEPTH; i++) begin
      haz[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (j < i && v_q[j] && we_q[j] && a_q[j] == a_q[i]) haz[i] = 1'b1;
      rd_ok[i] = v_q[i] && !we_q[i] && !haz[i] &&
                 !bank_busy[BW'(bank_index(32'(a_q[i]), BW))];
      wr_ok[i] = v_q[i] && we_q[i] &&
                 !bank_busy[BW'(bank_index(32'(a_q[i]), BW))];
    end
  end

  always_comb begin : pick
    rd_any = |rd_ok;
    wr_any = |wr_ok;
    rd_idx = '0;
    wr_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (rd_ok[i]) rd_idx = IW'(i);
      if (wr_ok[i]) wr_idx = IW'(i);
    end
    sel = rd_any ? rd_idx : wr_idx;
  end

  assign iss_valid = rd_any || wr_any;
  assign iss_we    = we_q[sel];
  assign iss_addr  = a_q[sel];
  assign iss_data  = d_q[sel];
  assign iss_tag   = t_q[sel];
  assign full      = (cnt_q == CW'(DEPTH));

  always_comb begin : next_state
    int src;
    int pos;
    for (int i = 0; i < DEPTH; i++) begin
      src = (iss_valid && i >= int'(sel)) ? i + 1 : i;
      if (src < DEPTH) begin
        v_n[i]  = v_q[IW'(src)];
        we_n[i] = we_q[IW'(src)];
        a_n[i]  = a_q[IW'(src)];
        d_n[i]  = d_q[IW'(src)];
        t_n[i]  = t_q[IW'(src)];
      end else begin
        v_n[i]  = 1'b0;
        we_n[i] = 1'b0;
        a_n[i]  = '0;
        d_n[i]  = '0;
        t_n[i]  = '0;
      end
    end
    pos = int'(cnt_q) - (iss_valid ? 1 : 0);
    for (int i = 0; i < DEPTH; i++) begin
      if (push && i == pos) begin
        v_n[i]  = 1'b1;
        we_n[i] = push_we;
        a_n[i]  = push_addr;
        d_n[i]  = push_data;
        t_n[i]  = push_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= '0;
      we_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        a_q[i] <= '0;
        d_q[i] <= '0;
        t_q[i] <= '0;
      end
    end else begin
      v_q   <= v_n;
      we_q  <= we_n;
      cnt_q <= cnt_q + CW'(push) - CW'(iss_valid);
      for (int i = 0; i < DEPTH; i++) begin
        a_q[i] <= a_n[i];
        d_q[i] <= d_n[i];
        t_q[i] <= t_n[i];
      end
    end
  end

  // R7: occupancy never exceeds the queue depth
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R7: occupancy counter agrees with the live entries
  assert_count_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(v_q) == int'(cnt_q));

  // R5: a write leaves the port only when no read could take it
  assert_write_yields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_we) |-> !rd_any);

  // R6: an issued read has no older write to its address still queued
  assert_read_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_we) |-> !haz[sel]);

endmodule

// File: rtl/iq_bank_timer.sv
`timescale 1ns/1ps
module iq_bank_timer
  import interleave_pkg::*;
#(
  parameter int NB   = 8,
  parameter int BUSY = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  iss_valid,
  input  logic [$clog2(NB)-1:0] iss_bank,
  output logic [NB-1:0]         busy
);
  localparam int BW  = $clog2(NB);
  localparam int CTW = $clog2(BUSY + 1);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CTW-1:0] c_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              c_q <= '0;
      else if (iss_valid && iss_bank == BW'(b)) c_q <= CTW'(busy_reload(BUSY));
      else if (c_q != '0)                      c_q <= c_q - 1'b1;
    end
    assign busy[b] = (c_q != '0);

    // R3: a bank only turns busy through an access granted on the previous cycle
    assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[b]) |-> $past(iss_valid && iss_bank == BW'(b)));
  end

  // R3: the queue never grants a bank that the timer holds busy
  assert_no_issue_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !busy[iss_bank]);

endmodule

// File: rtl/iq_return.sv
`timescale 1ns/1ps
module iq_return #(
  parameter int LAT = 3,
  parameter int NB  = 8,
  parameter int DW  = 16,
  parameter int TW  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_issue,
  input  logic [$clog2(NB)-1:0] rd_bank,
  input  logic [TW-1:0]         rd_tag,
  input  logic [NB*DW-1:0]      bank_rdata,
  output logic                  rsp_valid,
  output logic [TW-1:0]         rsp_tag,
  output logic [DW-1:0]         rsp_data
);
  localparam int BW = $clog2(NB);

  logic [LAT-1:0] v_q;
  logic [BW-1:0]  b_q [LAT];
  logic [TW-1:0]  t_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= '0;
    else begin
      v_q[0] <= rd_issue;
      for (int k = 1; k < LAT; k++) v_q[k] <= v_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    b_q[0] <= rd_bank;
    t_q[0] <= rd_tag;
    for (int k = 1; k < LAT; k++) begin
      b_q[k] <= b_q[k-1];
      t_q[k] <= t_q[k-1];
    end
  end

  assign rsp_valid = v_q[LAT-1];
  assign rsp_tag   = t_q[LAT-1];

  always_comb begin
    rsp_data = '0;
    for (int b = 0; b < NB; b++)
      if (b_q[LAT-1] == BW'(b)) rsp_data = bank_rdata[b*DW +: DW];
  end

endmodule

// File: rtl/interleave_sched.sv
`timescale 1ns/1ps
module interleave_sched
  import interleave_pkg::*;
#(
  parameter int NB    = 8,
  parameter int BUSY  = 4,
  parameter int LAT   = 3,
  parameter int DEPTH = 8,
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int TW    = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_we,
  input  logic [AW-1:0]              req_addr,
  input  logic [DW-1:0]              req_wdata,
  input  logic [TW-1:0]              req_tag,
  output logic [NB-1:0]              bank_en,
  output logic                       bank_we,
  output logic [AW-$clog2(NB)-1:0]   bank_row,
  output logic [DW-1:0]              bank_wdata,
  input  logic [NB*DW-1:0]           bank_rdata,
  output logic                       rsp_valid,
  output logic [TW-1:0]              rsp_tag,
  output logic [DW-1:0]              rsp_data
);
  localparam int BW = $clog2(NB);
  localparam int RW = AW - BW;

  // Named internal events
  logic          q_full;
  logic          push;
  logic          iss_valid;
  logic          iss_we;
  logic          iss_read;
  logic [AW-1:0] iss_addr;
  logic [DW-1:0] iss_data;
  logic [TW-1:0] iss_tag;
  logic [BW-1:0] iss_bank;
  logic [RW-1:0] iss_row;
  logic [NB-1:0] bank_busy;

  assign req_ready = !q_full;
  assign push      = req_valid && req_ready;
  assign iss_read  = iss_valid && !iss_we;
  assign iss_bank  = BW'(bank_index(32'(iss_addr), BW));
  assign iss_row   = RW'(row_index(32'(iss_addr), BW));

  iq_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW), .NB(NB)) queue_i (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_we(req_we), .push_addr(req_addr),
    .push_data(req_wdata), .push_tag(req_tag),
    .bank_busy(bank_busy), .full(q_full),
    .iss_valid(iss_valid), .iss_we(iss_we), .iss_addr(iss_addr),
    .iss_data(iss_data), .iss_tag(iss_tag)
  );

  iq_bank_timer #(.NB(NB), .BUSY(BUSY)) timer_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_bank(iss_bank), .busy(bank_busy)
  );

  iq_return #(.LAT(LAT), .NB(NB), .DW(DW), .TW(TW)) return_i (
    .clk(clk), .rst_n(rst_n),
    .rd_issue(iss_read), .rd_bank(iss_bank), .rd_tag(iss_tag),
    .bank_rdata(bank_rdata),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  always_comb begin
    for (int b = 0; b < NB; b++) bank_en[b] = iss_valid && (iss_bank == BW'(b));
  end

  assign bank_we    = iss_we;
  assign bank_row   = iss_row;
  assign bank_wdata = iss_data;

  // R4: never more than one bank strobed per cycle
  assert_onehot_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en));

endmodule

// File: tb/interleave_sched_tb_top.sv
`timescale 1ns/1ps
module interleave_sched_tb_top;
  localparam int NB = 8, BUSY = 4, LAT = 3, DEPTH = 8, AW = 6, DW = 16, TW = 5;
  localparam int BW = 3, RW = AW - BW, WORDS = 64, LOGN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [TW-1:0] req_tag = '0;
  logic          req_ready, bank_we, rsp_valid;
  logic [NB-1:0] bank_en;
  logic [RW-1:0] bank_row;
  logic [DW-1:0] bank_wdata, rsp_data;
  logic [TW-1:0] rsp_tag;
  logic [NB*DW-1:0] bank_rdata = '0;

  interleave_sched #(.NB(NB), .BUSY(BUSY), .LAT(LAT), .DEPTH(DEPTH),
                     .AW(AW), .DW(DW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
    .bank_en(bank_en), .bank_we(bank_we), .bank_row(bank_row),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  int acc_n = 0, iss_n = 0, rd_sent = 0, rsp_n = 0, rdy_low = 0;
  bit done = 1'b0;
  logic [TW-1:0] next_tag = '0;
  logic [DW-1:0] ref_mem [WORDS];
  logic [DW-1:0] bank_mem [WORDS];
  logic [DW-1:0] exp_data [32];
  bit            outst [32];
  int  log_addr [LOGN];
  bit  log_we [LOGN];
  int  log_cyc [LOGN];
  int  last_iss [NB];
  int  rdq [LOGN];
  int  rdq_wr = 0, rdq_rd = 0;
  bit  new_v = 1'b0;
  int  new_b = 0;
  logic [DW-1:0] new_d = '0;
  bit  pv [LAT];
  int  pb [LAT];
  logic [DW-1:0] pd [LAT];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Bank model, output side: shift the read pipeline and drive the data buses.
  always @(posedge clk) begin
    cyc++;
    for (int k = LAT - 1; k > 0; k--) begin
      pv[k] = pv[k-1]; pb[k] = pb[k-1]; pd[k] = pd[k-1];
    end
    pv[0] = new_v; pb[0] = new_b; pd[0] = new_d;
    new_v = 1'b0;
    for (int b = 0; b < NB; b++) bank_rdata[b*DW +: DW] = DW'(16'hA500 + b);
    if (pv[LAT-1]) bank_rdata[pb[LAT-1]*DW +: DW] = pd[LAT-1];
  end

  // Monitor and bank model, input side, sampled mid-cycle.
  always @(negedge clk) begin
    int occ;
    int b;
    int addr;
    if (rst_n) begin
      occ = acc_n - iss_n;
      check(req_ready == (occ < DEPTH), "R7 ready vs occupancy", int'(req_ready), int'(occ < DEPTH));
      if (!req_ready) rdy_low++;
      check($countones(bank_en) <= 1, "R4 one strobe", $countones(bank_en), 1);
      if (bank_en != '0) begin
        b = 0;
        for (int k = 0; k < NB; k++) if (bank_en[k]) b = k;
        check(cyc - last_iss[b] >= BUSY, "R3 busy window", cyc - last_iss[b], BUSY);
        last_iss[b] = cyc;
        addr = int'(bank_row) * NB + b;
        log_addr[iss_n] = addr; log_we[iss_n] = bank_we; log_cyc[iss_n] = cyc;
        if (bank_we) bank_mem[addr] = bank_wdata;
        else begin
          new_v = 1'b1; new_b = b; new_d = bank_mem[addr];
          rdq[rdq_wr] = cyc; rdq_wr++;
        end
        iss_n++;
      end
      if (rsp_valid) begin
        check(rdq_rd < rdq_wr && cyc - rdq[rdq_rd] == LAT, "R8 latency",
              cyc - rdq[rdq_rd], LAT);
        rdq_rd++;
        check(outst[rsp_tag], "R8 tag outstanding", int'(rsp_tag), int'(rsp_tag));
        check(rsp_data == exp_data[rsp_tag], "R9 read data", int'(rsp_data), int'(exp_data[rsp_tag]));
        outst[rsp_tag] = 1'b0;
        rsp_n++;
      end
    end
  end

  task automatic send(bit we, int addr, int data);
    req_valid = 1'b1; req_we = we; req_addr = AW'(addr);
    req_wdata = DW'(data); req_tag = next_tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    acc_n++;
    if (we) ref_mem[addr] = DW'(data);
    else begin
      exp_data[next_tag] = ref_mem[addr]; outst[next_tag] = 1'b1;
      next_tag++; rd_sent++;
    end
    #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (acc_n != iss_n || rsp_n != rd_sent) @(negedge clk);
    repeat (BUSY + LAT + 2) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic check_order(int s, int n, int exp_a[4], bit exp_w[4], string req);
    for (int k = 0; k < n; k++) begin
      check(log_addr[s+k] == exp_a[k], req, log_addr[s+k], exp_a[k]);
      check(log_we[s+k] == exp_w[k], req, int'(log_we[s+k]), int'(exp_w[k]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    int s, bad;
    logic [15:0] lf;
    for (int i = 0; i < WORDS; i++) begin ref_mem[i] = '0; bank_mem[i] = '0; end
    for (int i = 0; i < 32; i++) begin outst[i] = 1'b0; exp_data[i] = '0; end
    for (int i = 0; i < NB; i++) last_iss[i] = -100;
    for (int k = 0; k < LAT; k++) begin pv[k] = 1'b0; pb[k] = 0; pd[k] = '0; end

    // R1: state under reset
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    check(bank_en == '0, "R1 no strobe in reset", int'(bank_en), 0);
    check(rsp_valid == 1'b0, "R1 no response in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2/R4: sequential write fill, one per cycle in address order
    s = iss_n;
    for (int i = 0; i < WORDS; i++) send(1'b1, i, i * 37 + 5);
    wait_idle();
    check(log_cyc[s+WORDS-1] - log_cyc[s] == WORDS - 1, "R4 write stream rate",
          log_cyc[s+WORDS-1] - log_cyc[s], WORDS - 1);
    bad = 0;
    for (int i = 0; i < WORDS; i++) if (log_addr[s+i] != i || !log_we[s+i]) bad++;
    check(bad == 0, "R2 bank/row decode on writes", bad, 0);

    // R2/R4/R9: sequential read stream
    s = iss_n;
    for (int i = 0; i < WORDS; i++) send(1'b0, i, 0);
    wait_idle();
    check(log_cyc[s+WORDS-1] - log_cyc[s] == WORDS - 1, "R4 read stream rate",
          log_cyc[s+WORDS-1] - log_cyc[s], WORDS - 1);
    bad = 0;
    for (int i = 0; i < WORDS; i++) if (log_addr[s+i] != i || log_we[s+i]) bad++;
    check(bad == 0, "R2 bank/row decode on reads", bad, 0);

    // R3: same-bank reads issue exactly BUSY apart
    s = iss_n;
    send(1'b0, 0, 0); send(1'b0, 8, 0); send(1'b0, 16, 0); send(1'b0, 24, 0);
    wait_idle();
    for (int k = 1; k < 4; k++)
      check(log_cyc[s+k] - log_cyc[s+k-1] == BUSY, "R3 same-bank spacing",
            log_cyc[s+k] - log_cyc[s+k-1], BUSY);

    // R5: a read to a free bank passes writes held on a busy bank
    s = iss_n;
    send(1'b1, 0, 16'h0111); send(1'b1, 8, 16'h0222); send(1'b1, 16, 16'h0333); send(1'b0, 1, 0);
    wait_idle();
    check_order(s, 4, '{0, 1, 8, 16}, '{1'b1, 1'b0, 1'b1, 1'b1}, "R5 read bypass order");

    // R5: oldest ready read first among several reads
    s = iss_n;
    send(1'b1, 0, 16'h0444); send(1'b0, 8, 0); send(1'b0, 16, 0); send(1'b0, 1, 0);
    wait_idle();
    check_order(s, 4, '{0, 1, 8, 16}, '{1'b1, 1'b0, 1'b0, 1'b0}, "R5 oldest read first");

    // R6/R9: read waits for older write to the same word
    s = iss_n;
    send(1'b1, 0, 16'h0555); send(1'b1, 8, 16'h0666); send(1'b0, 8, 0);
    wait_idle();
    check_order(s, 3, '{0, 8, 8, 0}, '{1'b1, 1'b1, 1'b0, 1'b0}, "R6 same-address order");

    // R7: queue saturates on a single hot bank
    bad = rdy_low;
    for (int i = 0; i < 16; i++) send(1'b1, 3 + 8 * (i % 8), 1000 + i);
    wait_idle();
    check(rdy_low > bad, "R7 ready drops when full", rdy_low - bad, 1);

    // R9: pseudo-random mix over all banks and rows
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send(lf[0], int'(lf[6:1]), int'(lf[15:7]) * 3 + n);
    end
    wait_idle();
    check(rsp_n == rd_sent, "R9 one response per read", rsp_n, rd_sent);
    bad = 0;
    for (int i = 0; i < 32; i++) if (outst[i]) bad++;
    check(bad == 0, "R8 no tag left outstanding", bad, 0);

    done = 1'b1;
    finish_run();
  end

endmodule